// File: doc/BRIEF.md
# Banked Memory and Port Decoder

This block sits between the 16-bit address bus of a small 8-bit processor and the resources that bus reaches. The top two address bits pick one of four 16 KiB banks: a 256-byte RAM, a fixed program ROM, a peripheral window, and an empty bank. The block routes each read and write to the right place and returns the read data to the core in the same cycle.

The processor also has short port instructions. An input instruction carries a 3-bit port number and an output instruction a 5-bit one. The decoder folds these port numbers into the peripheral window, so a port access and an ordinary load or store to the same peripheral address have the same effect. The peripheral window holds a button input, an 8-bit output port that drives LEDs, a 16-bit tone divisor and a tone enable bit.

At reset the block also chooses where the core starts. If a boot button is held on the first clock after reset is released, the core starts at RAM address 0x0000. Otherwise it starts at the ROM base address 0x4000.

Top module: `bank_io_decoder`

## Requirements
- R1: The effective address bits [15:14] pick the bank: 00 is RAM, 01 is ROM, 10 is peripherals, 11 is empty. A read from RAM returns `ram_rdata` and a read from ROM returns `rom_rdata`. `cpu_rdata` is 0x00 in any cycle with no read strobe.
- R2: RAM is addressed by effective address bits [7:0], so RAM addresses wrap modulo 256 inside the bank. `ram_we` is high only for a write to bank 00, and `ram_wdata` carries `cpu_wdata`.
- R3: `rom_addr` carries effective address bits [13:0]. A write to the ROM bank asserts no RAM write and changes no peripheral register.
- R4: An input instruction on port n reads address 0x8000 + n[2:0]. Address 0x8000 reads as 0x01 while `btn_user` is high and 0x00 while it is low. Addresses 0x8001 to 0x8007 read as 0x00.
- R5: An output instruction on port n writes address 0x8000 + n. Ports 0 to 7 therefore land on read-only addresses and have no effect.
- R6: The peripheral registers are decoded on the full offset [13:0] within the bank. Offset 0x008 is the LED port, 0x009 is the low byte of the tone divisor, 0x00A is the high byte of the tone divisor, and bit 0 of offset 0x00B is the tone enable. Writes to any other peripheral offset are ignored. Reads of the write-only offsets return 0x00.
- R7: The peripheral registers clear to zero on reset. A write takes effect on the clock edge that ends the write cycle.
- R8: `boot_addr` reads 0x4000 until the first clock edge after reset is released. That edge samples `btn_boot` once and sets `boot_valid`. If the button was high, `boot_addr` becomes 0x0000. Later changes of `btn_boot` have no effect until the next reset.
- R9: Bank 11 reads as 0x00 and ignores writes.
- R10: While an input or output port strobe is active, the memory strobes are ignored. If both port strobes are active together, the output strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Memory address from the core |
| cpu_rd | input | 1 | Memory read strobe |
| cpu_wr | input | 1 | Memory write strobe |
| cpu_wdata | input | 8 | Write data from the core |
| io_rd | input | 1 | Input-instruction strobe |
| io_wr | input | 1 | Output-instruction strobe |
| io_port | input | 5 | Port number of the port instruction |
| cpu_rdata | output | 8 | Read data returned to the core |
| ram_addr | output | 8 | RAM array address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM array read data |
| rom_addr | output | 14 | ROM array address |
| rom_rdata | input | 8 | ROM array read data |
| btn_user | input | 1 | User button level |
| btn_boot | input | 1 | Boot-select button level |
| led_port | output | 8 | LED output port |
| tone_div | output | 16 | Tone generator divisor |
| tone_en | output | 1 | Tone generator enable |
| boot_addr | output | 16 | Start address for the core |
| boot_valid | output | 1 | Start address has been sampled |

## Verification
The hardest cases to reach from the ports are the collisions. One is a port strobe and a memory strobe active in the same cycle. Another is an address that matches a register offset only in its low bits, such as 0x8408. The stimulus drives a store to RAM together with an output instruction, then stores to aliasing peripheral addresses, and checks that only the intended register moves. The boot choice is only sampled in the first cycle after reset. To cover it, the bench applies reset twice, once with the button released and once with it held, and toggles the button afterwards to show the sampled value is kept.

// File: rtl/bio_pkg.sv
package bio_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PORT_W = 5;
  localparam int OFF_W  = ADDR_W - 2;

  typedef enum logic [1:0] {
    BANK_RAM    = 2'b00,
    BANK_ROM    = 2'b01,
    BANK_PERIPH = 2'b10,
    BANK_NONE   = 2'b11
  } bank_e;

  localparam logic [ADDR_W-1:0] ROM_BASE    = 16'h4000;
  localparam logic [ADDR_W-1:0] PERIPH_BASE = 16'h8000;

  localparam logic [OFF_W-1:0] OFF_BUTTON  = 14'h000;
  localparam logic [OFF_W-1:0] OFF_LED     = 14'h008;
  localparam logic [OFF_W-1:0] OFF_TONE_LO = 14'h009;
  localparam logic [OFF_W-1:0] OFF_TONE_HI = 14'h00A;
  localparam logic [OFF_W-1:0] OFF_TONE_EN = 14'h00B;

  function automatic bank_e bank_of(input logic [ADDR_W-1:0] a);
    return bank_e'(a[ADDR_W-1:ADDR_W-2]);
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  // Output ports use all five bits, input ports only the low three.
  function automatic logic [ADDR_W-1:0] port_to_addr(input logic is_out,
                                                     input logic [PORT_W-1:0] port);
    logic [PORT_W-1:0] p;
    p = is_out ? port : {2'b00, port[2:0]};
    return PERIPH_BASE | {{(ADDR_W-PORT_W){1'b0}}, p};
  endfunction
endpackage

// File: rtl/bio_access_mux.sv
module bio_access_mux
  import bio_pkg::*;
(
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic              acc_io
);
  always_comb begin
    acc_io = io_rd | io_wr;
    if (io_wr) begin
      eff_addr = port_to_addr(1'b1, io_port);
      acc_rd   = 1'b0;
      acc_wr   = 1'b1;
    end else if (io_rd) begin
      eff_addr = port_to_addr(1'b0, io_port);
      acc_rd   = 1'b1;
      acc_wr   = 1'b0;
    end else begin
      eff_addr = cpu_addr;
      acc_rd   = cpu_rd;
      acc_wr   = cpu_wr;
    end
  end
endmodule

// File: rtl/bio_periph.sv
module bio_periph
  import bio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              btn_user,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] led_port,
  output logic [2*DATA_W-1:0] tone_div,
  output logic              tone_en
);
  localparam int TONE_BYTES = 2;
  localparam logic [OFF_W-1:0] TONE_OFF [TONE_BYTES] = '{OFF_TONE_LO, OFF_TONE_HI};

  logic             in_bank;
  logic [OFF_W-1:0] off;
  logic             wr_hit;

  assign in_bank = (bank_of(eff_addr) == BANK_PERIPH);
  assign off     = offset_of(eff_addr);
  assign wr_hit  = acc_wr & in_bank;

  always_comb begin
    rdata = '0;
    if (acc_rd && in_bank && off == OFF_BUTTON) rdata = {{(DATA_W-1){1'b0}}, btn_user};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        led_port <= '0;
    else if (wr_hit && off == OFF_LED) led_port <= wdata;
  end

  for (genvar i = 0; i < TONE_BYTES; i++) begin : g_tone
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            tone_div[i*DATA_W +: DATA_W] <= '0;
      else if (wr_hit && off == TONE_OFF[i]) tone_div[i*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            tone_en <= 1'b0;
    else if (wr_hit && off == OFF_TONE_EN) tone_en <= wdata[0];
  end
endmodule

// File: rtl/bio_boot.sv
module bio_boot
  import bio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_boot,
  output logic [ADDR_W-1:0] boot_addr,
  output logic              boot_valid
);
  logic from_ram;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_valid <= 1'b0;
      from_ram   <= 1'b0;
    end else if (!boot_valid) begin
      boot_valid <= 1'b1;
      from_ram   <= btn_boot;
    end
  end

  assign boot_addr = from_ram ? '0 : ROM_BASE;
endmodule

// File: rtl/bank_io_decoder.sv
module bank_io_decoder
  import bio_pkg::*;
#(
  parameter int RAM_AW = 8,
  parameter int ROM_AW = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                io_rd,
  input  logic                io_wr,
  input  logic [PORT_W-1:0]   io_port,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic                ram_we,
  output logic [DATA_W-1:0]   ram_wdata,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic [ROM_AW-1:0]   rom_addr,
  input  logic [DATA_W-1:0]   rom_rdata,
  input  logic                btn_user,
  input  logic                btn_boot,
  output logic [DATA_W-1:0]   led_port,
  output logic [2*DATA_W-1:0] tone_div,
  output logic                tone_en,
  output logic [ADDR_W-1:0]   boot_addr,
  output logic                boot_valid
);
  // Named internal events, also seen by the bound checker
  logic [ADDR_W-1:0] eff_addr;
  logic              acc_rd;
  logic              acc_wr;
  logic              acc_io;
  bank_e             bank;
  logic [DATA_W-1:0] periph_rdata;

  bio_access_mux u_mux (
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_port  (io_port),
    .eff_addr (eff_addr),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .acc_io   (acc_io)
  );

  bio_periph u_periph (
    .clk      (clk),
    .rst_n    (rst_n),
    .eff_addr (eff_addr),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .wdata    (cpu_wdata),
    .btn_user (btn_user),
    .rdata    (periph_rdata),
    .led_port (led_port),
    .tone_div (tone_div),
    .tone_en  (tone_en)
  );

  bio_boot u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn_boot   (btn_boot),
    .boot_addr  (boot_addr),
    .boot_valid (boot_valid)
  );

  assign bank      = bank_of(eff_addr);
  assign ram_addr  = eff_addr[RAM_AW-1:0];
  assign rom_addr  = eff_addr[ROM_AW-1:0];
  assign ram_wdata = cpu_wdata;
  assign ram_we    = acc_wr && (bank == BANK_RAM);

  always_comb begin
    cpu_rdata = '0;
    if (acc_rd) begin
      unique case (bank)
        BANK_RAM:    cpu_rdata = ram_rdata;
        BANK_ROM:    cpu_rdata = rom_rdata;
        BANK_PERIPH: cpu_rdata = periph_rdata;
        BANK_NONE:   cpu_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bank_io_decoder_chk.sv
module bank_io_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] eff_addr,
  input logic        acc_rd,
  input logic        acc_wr,
  input logic        acc_io,
  input logic        ram_we,
  input logic [7:0]  cpu_rdata,
  input logic [7:0]  led_port,
  input logic [15:0] tone_div,
  input logic        tone_en,
  input logic [15:0] boot_addr,
  input logic        boot_valid
);
  AST_RAM_WE_IN_RAM_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (acc_wr && eff_addr[15:14] == 2'b00)); // R2

  AST_EMPTY_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && eff_addr[15:14] == 2'b11) |-> (cpu_rdata == 8'h00)); // R9

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |-> (cpu_rdata == 8'h00)); // R1

  AST_PORT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_io |-> (eff_addr[15:5] == 11'h400 && !ram_we)); // R10

  AST_LED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr && eff_addr == 16'h8008) |=> $stable(led_port)); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (led_port == 8'h00 && tone_div == 16'h0000 && !tone_en)); // R7

  AST_BOOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_valid && $past(boot_valid)) |-> $stable(boot_addr)); // R8
endmodule

bind bank_io_decoder bank_io_decoder_chk u_chk (.*);

// File: tb/bank_io_decoder_tb.sv
module bank_io_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [4:0]  io_port = '0;
  logic        btn_user = 1'b0, btn_boot = 1'b0;
  logic [7:0]  cpu_rdata, ram_wdata, ram_rdata, rom_rdata, led_port;
  logic [7:0]  ram_addr;
  logic [13:0] rom_addr;
  logic        ram_we, tone_en, boot_valid;
  logic [15:0] tone_div, boot_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model state
  int m_led = 0, m_tone = 0, m_en = 0, m_boot_done = 0, m_boot_ram = 0;

  always #10 clk = ~clk;

  // Stand-in arrays with recognisable contents
  assign ram_rdata = ram_addr ^ 8'h5A;
  assign rom_rdata = rom_addr[7:0] + 8'd3;

  bank_io_decoder u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(output bit rd, output bit wr);
    rd = 0; wr = 0;
    if (io_wr) begin wr = 1; return 32768 + int'(io_port); end
    if (io_rd) begin rd = 1; return 32768 + int'(io_port % 8); end
    rd = cpu_rd; wr = cpu_wr;
    return int'(cpu_addr);
  endfunction

  function automatic int exp_read();
    bit rd, wr; int a, b;
    a = eff(rd, wr);
    if (!rd) return 0;
    b = a / 16384;
    if (b == 0) return (a % 256) ^ 'h5A;
    if (b == 1) return ((a % 256) + 3) % 256;
    if (b == 2) return (a % 16384 == 0) ? int'(btn_user) : 0;
    return 0;
  endfunction

  // Compare every output against the model, then advance one clock
  task automatic tick();
    bit rd, wr; int a;
    #5;
    if (!rst_n) begin
      m_led = 0; m_tone = 0; m_en = 0; m_boot_done = 0; m_boot_ram = 0;
    end
    a = eff(rd, wr);
    chk("R1/R4/R9 rdata", int'(cpu_rdata), exp_read());
    chk("R2/R3/R9/R10 ram_we", int'(ram_we), (wr && a < 16384) ? 1 : 0);
    chk("R2 ram_addr", int'(ram_addr), a % 256);
    chk("R3 rom_addr", int'(rom_addr), a % 16384);
    if (ram_we) chk("R2 ram_wdata", int'(ram_wdata), int'(cpu_wdata));
    chk("R6/R7 led_port", int'(led_port), m_led);
    chk("R6/R7 tone_div", int'(tone_div), m_tone);
    chk("R6/R7 tone_en", int'(tone_en), m_en);
    chk("R8 boot_valid", int'(boot_valid), m_boot_done);
    chk("R8 boot_addr", int'(boot_addr), (m_boot_done && m_boot_ram) ? 0 : 'h4000);
    @(posedge clk);
    if (rst_n) begin
      if (wr) begin
        if (a == 'h8008) m_led = cpu_wdata;
        if (a == 'h8009) m_tone = (m_tone / 256) * 256 + cpu_wdata;
        if (a == 'h800A) m_tone = cpu_wdata * 256 + m_tone % 256;
        if (a == 'h800B) m_en = cpu_wdata % 2;
      end
      if (!m_boot_done) begin m_boot_done = 1; m_boot_ram = btn_boot; end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cpu_rd = 0; cpu_wr = 0; io_rd = 0; io_wr = 0;
  endtask
  task automatic mem_rd(input logic [15:0] a);
    idle(); cpu_addr = a; cpu_rd = 1; tick();
  endtask
  task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
    idle(); cpu_addr = a; cpu_wdata = d; cpu_wr = 1; tick();
  endtask
  task automatic port_in(input logic [4:0] p);
    idle(); io_port = p; io_rd = 1; tick();
  endtask
  task automatic port_out(input logic [4:0] p, input logic [7:0] d);
    idle(); io_port = p; cpu_wdata = d; io_wr = 1; tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();                          // R7 R8 reset state
    rst_n = 1; tick(); tick();               // R8 default boot from ROM
    btn_boot = 1; tick(); btn_boot = 0;      // R8 late press ignored
    mem_rd(16'h0012); mem_rd(16'h3F34);      // R1 R2 RAM read, wrap
    mem_wr(16'h0105, 8'hC3);                 // R2 RAM write
    mem_rd(16'h4000); mem_rd(16'h7ABC);      // R1 R3 ROM read
    mem_wr(16'h4008, 8'h77);                 // R3 ROM write ignored
    btn_user = 0; mem_rd(16'h8000);          // R4
    btn_user = 1; mem_rd(16'h8000); port_in(5'd0);
    port_in(5'd3); port_in(5'd13);           // R4 port folding
    port_out(5'd8, 8'hA5);                   // R5 LED
    port_out(5'd9, 8'h34); port_out(5'd10, 8'h12); port_out(5'd11, 8'h03);
    port_out(5'd3, 8'hFF);                   // R5 read-only port ignored
    mem_wr(16'h8008, 8'h3C);                 // R6 store reaches LED
    mem_wr(16'h800C, 8'hEE);                 // R6 unused offset
    mem_wr(16'h8408, 8'h99);                 // R6 aliased offset ignored
    mem_rd(16'h8008); mem_rd(16'h800A);      // R6 write-only reads 0
    mem_wr(16'h800B, 8'h02);                 // R6 enable bit0 only
    mem_rd(16'hC000); mem_wr(16'hC008, 8'h11); // R9
    idle(); cpu_addr = 16'h0000; cpu_rd = 1; cpu_wr = 1; cpu_wdata = 8'h5E;
    io_port = 5'd8; io_wr = 1; io_rd = 1; tick(); // R10 port wins
    idle(); cpu_addr = 16'h0020; cpu_rd = 1; io_rd = 1; io_port = 5'd0; tick(); // R10
    idle(); tick();                          // R1 idle read zero
    rst_n = 0; btn_boot = 1; tick();         // R7 clear, R8 reselect
    rst_n = 1; tick(); btn_boot = 0; tick(); tick(); // R8 boot from RAM
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule